// File: doc/BRIEF.md
# Two-Step Command Watchdog Timer

This block is a down-counting watchdog timer driven through a small synchronous register bus. Software cannot start, refresh or stop the counter with a single write. Each action takes two writes to one command register: first a key word that arms the action, then the matching action word. Any other write to the command register drops the armed state and does nothing. The counter steps down only in cycles where the tick enable input is high. Once started, it must be refreshed with the same two-write sequence before it runs out.

When the running counter is at zero and a tick arrives, the block raises a reset request for a fixed number of cycles and stops. It also sets a sticky cause flag. The system reset does not clear this flag, so software can read it once the system is back up. The flag clears only on a power-on reset or when software writes 1 to it. A small action register selects the kind of reset the request stands for, and the block drives that selection out on `rst_kind`.

A build-time option removes the stop capability. In that variant the stop key is the same word as the start key, and a stop attempt leaves the counter running.

Top module: `armseq_wdog`

## Requirements
- R1: Register map on `bus_addr`: 0 is the command register (reads 0), 1 is the action register (bits 1:0), 2 is the cause flag (bit 0), 3 is the enabled flag (bit 0), 4 is the armed flag (bit 0, set while a key word is pending) and 5 is the counter value. `bus_rdata` is registered and shows the selected register one cycle after the address is presented. After power-on reset every readable value is 0 and `rst_req` is low.
- R2: Writing the start key (0x1E) and then the start word (0xE1) to address 0 loads the counter with all ones and sets the enabled flag. The armed flag reads 1 between the two writes and 0 after the second.
- R3: A start word written without a preceding start key has no effect. A write of any word other than the matching action word after a key clears the armed flag and performs no action, so a start word written after that also has no effect.
- R4: While enabled, the counter decreases by one only in cycles where `tick_en` is 1 and holds its value otherwise.
- R5: The start key followed by the start word, written while the counter runs, reloads it to all ones.
- R6: The stop key (0x2D) followed by the stop word (0xD2) clears the enabled flag. The counter then keeps its value regardless of `tick_en`.
- R7: A tick that arrives while the counter is enabled and at zero clears the enabled flag and drives `rst_req` high for exactly PULSE_LEN (16) consecutive cycles, starting at the next clock edge. With CNT_W bits, a tick on every cycle after a start gives 2^CNT_W cycles from the start write to `rst_req`.
- R8: An expiry sets the cause flag. The flag stays set through `rst`. Writing a word with bit 0 = 1 to address 2 clears it; writing bit 0 = 0 leaves it set.
- R9: `por` clears the cause flag, the action register and all other state.
- R10: The action register (encoding 0 = local core reset, 1 = internal-bus reset of all cores, 2 and 3 reserved) drives `rst_kind`. It keeps its value through `rst` and is cleared only by `por`.
- R11: With HAS_STOP = 0, the stop sequence has no effect and the counter keeps running and counting ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; the cause flag, the action register and the reset pulse survive it |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for `bus_addr` |
| tick_en | input | 1 | Counter decrement enable |
| rst_req | output | 1 | Reset request pulse issued at expiry |
| rst_kind | output | ACT_W | Reset type selected by the action register |

## Verification
A wrong armed state shows up on the next command write: an action word is either ignored or taken when it should not be. The armed flag read at address 4 exposes the error one cycle before that. A counter that slips or misses a tick changes the count readback within one cycle, and it moves the cycle on which `rst_req` rises, so the bench measures that distance exactly. A cause flag or pulse generator that the system reset wrongly clears shows up as a cause readback of 0 right after `rst`, or as a pulse shorter than 16 cycles.

// File: rtl/armseq_wdog_pkg.sv
package armseq_wdog_pkg;
  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_START = 2'd1,
    ARM_HALT  = 2'd2
  } arm_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAUSE = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd5;
endpackage

// File: rtl/armseq_cmd_decode.sv
module armseq_cmd_decode
  import armseq_wdog_pkg::*;
#(
  parameter int unsigned       DATA_W        = 32,
  parameter bit                HAS_STOP      = 1'b1,
  parameter logic [DATA_W-1:0] CODE_ARM_GO   = 'h1E,
  parameter logic [DATA_W-1:0] CODE_GO       = 'hE1,
  parameter logic [DATA_W-1:0] CODE_ARM_HALT = 'h2D,
  parameter logic [DATA_W-1:0] CODE_HALT     = 'hD2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              load_o,
  output logic              halt_o,
  output arm_e              arm_o
);
  arm_e arm_q;
  logic halt_key_hit;
  logic halt_word_hit;

  generate
    if (HAS_STOP) begin : g_halt
      assign halt_key_hit  = (cmd_data == CODE_ARM_HALT);
      assign halt_word_hit = cmd_wr && (arm_q == ARM_HALT) && (cmd_data == CODE_HALT);
    end else begin : g_no_halt
      // the stop key collapses onto the start key; no stop word exists
      assign halt_key_hit  = 1'b0;
      assign halt_word_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      arm_q <= ARM_NONE;
    end else if (cmd_wr) begin
      if (cmd_data == CODE_ARM_GO)  arm_q <= ARM_START;
      else if (halt_key_hit)        arm_q <= ARM_HALT;
      else                          arm_q <= ARM_NONE;
    end
  end

  assign load_o = cmd_wr && (arm_q == ARM_START) && (cmd_data == CODE_GO);
  assign halt_o = halt_word_hit;
  assign arm_o  = arm_q;
endmodule

// File: rtl/armseq_down_counter.sv
module armseq_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             halt,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = en_q && tick && at_zero && !load && !halt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= FULL;
      en_q  <= 1'b1;
    end else if (halt) begin
      en_q  <= 1'b0;
    end else if (en_q && tick) begin
      if (at_zero) en_q  <= 1'b0;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;
endmodule

// File: rtl/armseq_reset_pulse.sv
module armseq_reset_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por,
  input  logic expire,
  input  logic cause_clr,
  output logic req_o,
  output logic cause_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pcnt_q;
  logic          req_q;
  logic          cause_q;

  // only power-on reset touches this state: it must outlive the reset it requests
  always_ff @(posedge clk) begin
    if (por) begin
      pcnt_q  <= '0;
      req_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (expire) begin
        pcnt_q <= PW'(PULSE_LEN);
        req_q  <= 1'b1;
      end else if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
        req_q  <= (pcnt_q > PW'(1));
      end
      if (expire)         cause_q <= 1'b1;
      else if (cause_clr) cause_q <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/armseq_wdog.sv
module armseq_wdog
  import armseq_wdog_pkg::*;
#(
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       CNT_W         = 32,
  parameter int unsigned       PULSE_LEN     = 16,
  parameter int unsigned       ACT_W         = 2,
  parameter bit                HAS_STOP      = 1'b1,
  parameter logic [DATA_W-1:0] CODE_ARM_GO   = 'h1E,
  parameter logic [DATA_W-1:0] CODE_GO       = 'hE1,
  parameter logic [DATA_W-1:0] CODE_ARM_HALT = 'h2D,
  parameter logic [DATA_W-1:0] CODE_HALT     = 'hD2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              rst_req,
  output logic [ACT_W-1:0]  rst_kind
);
  logic             sys_clr;
  logic             cmd_wr;
  logic             cause_wr;
  logic             load;
  logic             halt;
  logic             expire;
  arm_e             arm_state;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_en;
  logic             cause_flag;
  logic [ACT_W-1:0] act_q;
  logic [DATA_W-1:0] rd_next;

  assign sys_clr  = rst || por;
  assign cmd_wr   = bus_we && (bus_addr == A_CMD);
  assign cause_wr = bus_we && (bus_addr == A_CAUSE) && bus_wdata[0];

  armseq_cmd_decode #(
    .DATA_W(DATA_W), .HAS_STOP(HAS_STOP),
    .CODE_ARM_GO(CODE_ARM_GO), .CODE_GO(CODE_GO),
    .CODE_ARM_HALT(CODE_ARM_HALT), .CODE_HALT(CODE_HALT)
  ) u_dec (
    .clk(clk), .clr(sys_clr), .cmd_wr(cmd_wr), .cmd_data(bus_wdata),
    .load_o(load), .halt_o(halt), .arm_o(arm_state)
  );

  armseq_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(sys_clr), .load(load), .halt(halt), .tick(tick_en),
    .count_o(cnt_val), .en_o(cnt_en), .expire_o(expire)
  );

  armseq_reset_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por(por), .expire(expire), .cause_clr(cause_wr),
    .req_o(rst_req), .cause_o(cause_flag)
  );

  // action selection persists across the system reset it configures
  always_ff @(posedge clk) begin
    if (por)                                 act_q <= '0;
    else if (bus_we && bus_addr == A_ACT)    act_q <= bus_wdata[ACT_W-1:0];
  end
  assign rst_kind = act_q;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_ACT:   rd_next[ACT_W-1:0] = act_q;
      A_CAUSE: rd_next[0]         = cause_flag;
      A_EN:    rd_next[0]         = cnt_en;
      A_ARM:   rd_next[0]         = (arm_state != ARM_NONE);
      A_CNT:   rd_next[CNT_W-1:0] = cnt_val;
      default: rd_next            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sys_clr) bus_rdata <= '0;
    else         bus_rdata <= rd_next;
  end
endmodule

// File: rtl/armseq_wdog_chk.sv
module armseq_wdog_chk
  import armseq_wdog_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       CNT_W     = 32,
  parameter int unsigned       PULSE_LEN = 16,
  parameter bit                HAS_STOP  = 1'b1,
  parameter logic [DATA_W-1:0] CODE_GO   = 'hE1
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              tick_en,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req,
  input logic              enabled,
  input arm_e              arm_state,
  input logic [CNT_W-1:0]  count,
  input logic              cause
);
  localparam int unsigned LW = $clog2(PULSE_LEN + 2) + 1;
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [LW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (por)          hi_len <= '0;
    else if (rst_req) hi_len <= hi_len + 1'b1;
    else              hi_len <= '0;
  end

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (rst || por)
    (bus_we && bus_addr == A_CMD && bus_wdata == CODE_GO && arm_state == ARM_START)
      |=> (enabled && count == FULL)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst || por)
    (!tick_en && !bus_we) |=> $stable(count)); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (por)
    $fell(rst_req) |-> (hi_len == LW'(PULSE_LEN))); // R7

  AST_STOP_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst || por)
    $rose(rst_req) |-> !enabled); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por)
    (cause && !(bus_we && bus_addr == A_CAUSE && bus_wdata[0])) |=> cause); // R8

  AST_NO_STOP_VARIANT: assert property (@(posedge clk) disable iff (rst || por)
    (!HAS_STOP && enabled && !(tick_en && count == '0)) |=> enabled); // R11
endmodule

bind armseq_wdog armseq_wdog_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN),
  .HAS_STOP(HAS_STOP), .CODE_GO(CODE_GO)
) u_chk (
  .clk(clk), .rst(rst), .por(por), .tick_en(tick_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_req(rst_req),
  .enabled(cnt_en), .arm_state(arm_state), .count(cnt_val), .cause(cause_flag)
);

// File: tb/tb_armseq_wdog.sv
`timescale 1ns/1ps
module tb_armseq_wdog;
  localparam int unsigned DW  = 32;
  localparam int unsigned CW  = 8;
  localparam int unsigned PL  = 16;
  localparam logic [DW-1:0] K_ARM_GO = 32'h1E, K_GO = 32'hE1;
  localparam logic [DW-1:0] K_ARM_HALT = 32'h2D, K_HALT = 32'hD2;
  localparam logic [DW-1:0] FULL = (1 << CW) - 1;

  logic clk = 0, rst = 1, por = 1;
  logic bus_we = 0, tick_en = 0;
  logic [2:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic req_a, req_b;
  logic [1:0] kind_a, kind_b;

  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  armseq_wdog #(.DATA_W(DW), .CNT_W(CW), .PULSE_LEN(PL), .HAS_STOP(1'b1)) dut (
    .clk(clk), .rst(rst), .por(por), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .tick_en(tick_en),
    .rst_req(req_a), .rst_kind(kind_a));

  armseq_wdog #(.DATA_W(DW), .CNT_W(CW), .PULSE_LEN(PL), .HAS_STOP(1'b0)) dut_ns (
    .clk(clk), .rst(rst), .por(por), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .tick_en(tick_en),
    .rst_req(req_b), .rst_kind(kind_b));

  // scoreboard
  logic [DW-1:0] exp_q[$];
  bit            sel_q[$];
  string         tag_q[$];
  logic          rd_go = 0;

  always @(negedge clk) begin
    if (rd_go) begin
      logic [DW-1:0] e, a;
      bit s;
      string t;
      e = exp_q.pop_front();
      s = sel_q.pop_front();
      t = tag_q.pop_front();
      a = s ? rdata_b : rdata_a;
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s: actual %0h expected %0h", t, a, e);
      end
      rd_go = 0;
    end
  end

  task automatic rd(input logic [2:0] addr, input logic [DW-1:0] e, input bit sel, input string t);
    @(negedge clk);
    bus_addr = addr;
    exp_q.push_back(e); sel_q.push_back(sel); tag_q.push_back(t);
    rd_go <= 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic chk(input string t, input logic [DW-1:0] a, input logic [DW-1:0] e);
    vectors++;
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", t, a, e);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic measure_expiry(input string t);
    int n;
    n = 0;
    tick_en = 1;
    while (req_a !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({t, " R7 cycles to rst_req"}, n, 1 << CW);
    n = 0;
    while (req_a === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk({t, " R7 pulse width"}, n, PL);
    tick_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    por = 0; rst = 0;
    // R1 reset state
    chk("R1 rst_req", req_a, 0);
    rd(3'd0, 0, 0, "R1 cmd reads 0");
    rd(3'd1, 0, 0, "R1 action");
    rd(3'd2, 0, 0, "R1 cause");
    rd(3'd3, 0, 0, "R1 enabled");
    rd(3'd4, 0, 0, "R1 armed");
    rd(3'd5, 0, 0, "R1 count");
    // R3 start word alone
    wr(3'd0, K_GO);
    rd(3'd3, 0, 0, "R3 go without key: enabled");
    // R2 start sequence
    wr(3'd0, K_ARM_GO);
    rd(3'd4, 1, 0, "R2 armed after key");
    wr(3'd0, K_GO);
    rd(3'd3, 1, 0, "R2 enabled");
    rd(3'd5, FULL, 0, "R2 count loaded");
    rd(3'd4, 0, 0, "R2 armed consumed");
    // R4 ticks only when tick_en
    ticks(10);
    repeat (5) @(negedge clk);
    ticks(3);
    rd(3'd5, FULL - 13, 0, "R4 count after 13 ticks");
    // R3 key then junk, then start word: nothing
    wr(3'd0, K_ARM_GO);
    wr(3'd0, 32'h55);
    rd(3'd4, 0, 0, "R3 armed cleared by junk");
    wr(3'd0, K_GO);
    rd(3'd5, FULL - 13, 0, "R3 no reload after junk");
    // R5 keepalive
    wr(3'd0, K_ARM_GO);
    wr(3'd0, K_GO);
    rd(3'd5, FULL, 0, "R5 keepalive reload");
    // R6 stop
    ticks(5);
    wr(3'd0, K_ARM_HALT);
    wr(3'd0, K_HALT);
    rd(3'd3, 0, 0, "R6 enabled cleared");
    ticks(20);
    rd(3'd5, FULL - 5, 0, "R6 count held");
    // R11 variant ignores stop
    rd(3'd3, 1, 1, "R11 variant still enabled");
    rd(3'd5, FULL - 25, 1, "R11 variant kept counting");
    // R10 action register
    wr(3'd1, 32'h1);
    rd(3'd1, 1, 0, "R10 action readback");
    chk("R10 rst_kind", kind_a, 1);
    // R7 expiry
    wr(3'd0, K_ARM_GO);
    wr(3'd0, K_GO);
    measure_expiry("run1");
    rd(3'd3, 0, 0, "R7 enabled cleared at expiry");
    rd(3'd2, 1, 0, "R8 cause set");
    // R8 survives rst
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    rd(3'd2, 1, 0, "R8 cause kept over rst");
    rd(3'd1, 1, 0, "R10 action kept over rst");
    chk("R10 rst_kind kept", kind_a, 1);
    wr(3'd2, 32'h0);
    rd(3'd2, 1, 0, "R8 write 0 keeps cause");
    wr(3'd2, 32'h1);
    rd(3'd2, 0, 0, "R8 write 1 clears cause");
    // R9 por clears
    wr(3'd0, K_ARM_GO);
    wr(3'd0, K_GO);
    measure_expiry("run2");
    rd(3'd2, 1, 0, "R9 cause set before por");
    @(negedge clk); por = 1;
    repeat (2) @(negedge clk); por = 0;
    rd(3'd2, 0, 0, "R9 cause cleared by por");
    rd(3'd1, 0, 0, "R9 action cleared by por");
    chk("R9 rst_req low", req_a, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule